// File: doc/BRIEF.md
# Register Dependency Wakeup Scoreboard

This block sits beside the issue window of an out-of-order core and tracks whether each physical register holds a result yet. It keeps one ready bit per physical register. For each register it also keeps a bit vector of the window slots waiting on it. A slot enters through the dispatch port with up to two source tags, an optional destination tag and a set of kind flags. A finished producer is reported on the completion port. The completion wakes every waiting slot in the same cycle and sets the register's ready bit. A clear port removes a squashed slot from every wait vector at once.

A slot whose sources are all ready raises its bit of `ready_vec` for one cycle. The pulse comes on the clock edge after the dispatch or completion that freed it, and the slot's class code rides alongside. A slot that pulses is released and may be dispatched again. Tags at or above the register count name registers the block does not track, and it ignores them everywhere. The dispatcher must not reuse a slot that is still waiting. It must not clear a slot in the same cycle it dispatches that slot. It must not name a destination register that still has waiting slots.

Top module: `wakeup_scoreboard`

## Requirements
- R1: After reset every register's ready bit is clear, so a dispatched source that is not flagged ready waits, and `ready_vec` is all zero.
- R2: A dispatch naming an in-range destination clears that register's ready bit and records the slot as its producer, so a later unflagged source on that register waits.
- R3: A source flagged ready at dispatch never waits, and a slot with no waiting source pulses on the next edge.
- R4: An unflagged source whose register's ready bit is already set is treated as ready at dispatch.
- R5: A completion on an in-range register sets its ready bit, empties its wait vector, clears its producer and wakes every slot waiting on it in the same cycle.
- R6: A slot waiting on two sources pulses only once both are resolved; two sources naming the same register are both resolved by one completion.
- R7: Tags greater than or equal to the register count are ignored: as a source they count as ready, as a destination or a completion they change no ready bit.
- R8: The class code sent with a pulse comes from the kind flags (bit 3 control, bit 2 memory, bit 1 integer, bit 0 floating point) with priority control=4, memory=3, integer=2, floating point=1, none=0.
- R9: When a dispatch source and a completion name the same register in one cycle, the completion is applied first and the source counts as ready.
- R10: A cleared slot is removed from every wait vector and never pulses, even when a completion it waited on comes in the same cycle or later.
- R11: Each pulse lasts exactly one cycle and appears only on the edge after a dispatch or completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch a slot this cycle |
| disp_id | input | ID_W | Window slot being dispatched |
| disp_kind | input | 4 | Kind flags: [3] control, [2] memory, [1] integer, [0] floating point |
| disp_s0_use | input | 1 | First source present |
| disp_s0_tag | input | TAG_W | First source register tag |
| disp_s0_rdy | input | 1 | Dispatcher believes first source ready |
| disp_s1_use | input | 1 | Second source present |
| disp_s1_tag | input | TAG_W | Second source register tag |
| disp_s1_rdy | input | 1 | Dispatcher believes second source ready |
| disp_d_use | input | 1 | Destination present |
| disp_d_tag | input | TAG_W | Destination register tag |
| cmpl_valid | input | 1 | A producer finished this cycle |
| cmpl_tag | input | TAG_W | Register written by the finished producer |
| clr_valid | input | 1 | Remove a squashed slot |
| clr_id | input | ID_W | Slot to remove |
| ready_vec | output | NUM_SLOTS | One-cycle ready pulse per slot |
| ready_cls | output | 3*NUM_SLOTS | Class code per slot, valid with its pulse |

## Verification
A stale ready bit shows up on the very next probe. A slot dispatched against that register either pulses one edge after dispatch when it should wait, or stays silent after the completion edge. A wait vector that keeps a bit after a completion or a clear shows up later. The slot then pulses on a completion it no longer depends on, or fails to pulse when it is reused. The random mix reuses slots and registers heavily, so such leftovers come to the surface within a few dozen cycles. Directed cases then pin down same-cycle ordering and out-of-range tags.

// File: rtl/ws_pkg.sv
package ws_pkg;

   localparam int KIND_W = 4;
   localparam int CLS_W  = 3;

   localparam int KIND_FP  = 0;
   localparam int KIND_INT = 1;
   localparam int KIND_MEM = 2;
   localparam int KIND_CTL = 3;

   typedef enum logic [CLS_W-1:0] {
      CLS_MISC = 3'd0,
      CLS_FP   = 3'd1,
      CLS_INT  = 3'd2,
      CLS_MEM  = 3'd3,
      CLS_CTL  = 3'd4
   } ws_cls_e;

   function automatic ws_cls_e ws_classify(input logic [KIND_W-1:0] kind);
      if (kind[KIND_CTL])      return CLS_CTL;
      else if (kind[KIND_MEM]) return CLS_MEM;
      else if (kind[KIND_INT]) return CLS_INT;
      else if (kind[KIND_FP])  return CLS_FP;
      else                     return CLS_MISC;
   endfunction

endpackage

// File: rtl/ws_regfile.sv
module ws_regfile #(
   parameter int NUM_PREGS = 16,
   parameter int NUM_SLOTS = 8,
   localparam int ID_W = $clog2(NUM_SLOTS)
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NUM_PREGS-1:0]                cmpl_hit,
   input  logic [NUM_PREGS-1:0]                dst_hit,
   input  logic [ID_W-1:0]                     dst_id,
   input  logic [NUM_PREGS-1:0][NUM_SLOTS-1:0] add_wait,
   input  logic [NUM_SLOTS-1:0]                drop_mask,
   output logic [NUM_PREGS-1:0]                reg_rdy,
   output logic [NUM_PREGS-1:0][NUM_SLOTS-1:0] waiters,
   output logic [NUM_PREGS-1:0]                prod_vld,
   output logic [NUM_PREGS-1:0][ID_W-1:0]      prod_id
);

   for (genvar r = 0; r < NUM_PREGS; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            reg_rdy[r]  <= 1'b0;
            waiters[r]  <= '0;
            prod_vld[r] <= 1'b0;
            prod_id[r]  <= '0;
         end else begin
            if (dst_hit[r]) begin
               reg_rdy[r]  <= 1'b0;
               prod_vld[r] <= 1'b1;
               prod_id[r]  <= dst_id;
            end else if (cmpl_hit[r]) begin
               reg_rdy[r]  <= 1'b1;
               prod_vld[r] <= 1'b0;
            end
            if (cmpl_hit[r])
               waiters[r] <= '0;
            else
               waiters[r] <= (waiters[r] | add_wait[r]) & ~drop_mask;
         end
      end
   end

endmodule

// File: rtl/ws_slot.sv
module ws_slot #(
   parameter int TAG_W = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                alloc,
   input  logic [1:0]          alloc_wait,
   input  logic [TAG_W-1:0]    alloc_tag0,
   input  logic [TAG_W-1:0]    alloc_tag1,
   input  ws_pkg::ws_cls_e     alloc_cls,
   input  logic                wake,
   input  logic [TAG_W-1:0]    wake_tag,
   input  logic                kill,
   output logic                busy,
   output logic                fire_q,
   output ws_pkg::ws_cls_e     cls_q
);
   import ws_pkg::*;

   logic [1:0]       wait_q;
   logic [TAG_W-1:0] tag0_q, tag1_q;
   ws_cls_e          cls_held;
   logic [1:0]       wait_nxt;
   logic             fire;

   always_comb begin
      wait_nxt[0] = wait_q[0] && (tag0_q != wake_tag);
      wait_nxt[1] = wait_q[1] && (tag1_q != wake_tag);
      fire = 1'b0;
      if (alloc)
         fire = ~|alloc_wait;
      else if (busy && !kill && wake)
         fire = ~|wait_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         wait_q   <= '0;
         tag0_q   <= '0;
         tag1_q   <= '0;
         cls_held <= CLS_MISC;
         fire_q   <= 1'b0;
         cls_q    <= CLS_MISC;
      end else begin
         if (alloc) begin
            busy     <= |alloc_wait;
            wait_q   <= alloc_wait;
            tag0_q   <= alloc_tag0;
            tag1_q   <= alloc_tag1;
            cls_held <= alloc_cls;
         end else if (kill) begin
            busy   <= 1'b0;
            wait_q <= '0;
         end else if (busy && wake) begin
            wait_q <= wait_nxt;
            if (fire) busy <= 1'b0;
         end
         fire_q <= fire;
         if (fire) cls_q <= alloc ? alloc_cls : cls_held;
      end
   end

endmodule

// File: rtl/wakeup_scoreboard.sv
module wakeup_scoreboard #(
   parameter int NUM_PREGS = 16,
   parameter int NUM_SLOTS = 8,
   parameter int TAG_W     = 5,
   localparam int ID_W     = $clog2(NUM_SLOTS),
   localparam int CLS_W    = ws_pkg::CLS_W,
   localparam int KIND_W   = ws_pkg::KIND_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       disp_valid,
   input  logic [ID_W-1:0]            disp_id,
   input  logic [KIND_W-1:0]          disp_kind,
   input  logic                       disp_s0_use,
   input  logic [TAG_W-1:0]           disp_s0_tag,
   input  logic                       disp_s0_rdy,
   input  logic                       disp_s1_use,
   input  logic [TAG_W-1:0]           disp_s1_tag,
   input  logic                       disp_s1_rdy,
   input  logic                       disp_d_use,
   input  logic [TAG_W-1:0]           disp_d_tag,
   input  logic                       cmpl_valid,
   input  logic [TAG_W-1:0]           cmpl_tag,
   input  logic                       clr_valid,
   input  logic [ID_W-1:0]            clr_id,
   output logic [NUM_SLOTS-1:0]       ready_vec,
   output logic [CLS_W*NUM_SLOTS-1:0] ready_cls
);
   import ws_pkg::*;

   if (NUM_PREGS < 2) begin : g_bad_pregs
      $error("wakeup_scoreboard: NUM_PREGS must be at least 2");
   end
   if (NUM_SLOTS < 2) begin : g_bad_slots
      $error("wakeup_scoreboard: NUM_SLOTS must be at least 2");
   end
   if ((1 << TAG_W) < NUM_PREGS) begin : g_bad_tag
      $error("wakeup_scoreboard: TAG_W too narrow for NUM_PREGS");
   end

   logic [NUM_PREGS-1:0]                reg_rdy;
   logic [NUM_PREGS-1:0][NUM_SLOTS-1:0] waiters;
   logic [NUM_PREGS-1:0]                prod_vld;
   logic [NUM_PREGS-1:0][ID_W-1:0]      prod_id;

   logic [NUM_PREGS-1:0] cmpl_hit, dst_hit, s0_oh, s1_oh, rdy_eff;
   logic [NUM_PREGS-1:0][NUM_SLOTS-1:0] add_wait;
   logic [NUM_SLOTS-1:0] id_oh, drop_mask, wake;
   logic s0_wait, s1_wait;
   ws_cls_e disp_cls;

   // Full-width tag compares: an out-of-range tag matches no register.
   for (genvar r = 0; r < NUM_PREGS; r++) begin : g_dec
      assign cmpl_hit[r] = cmpl_valid && (cmpl_tag == TAG_W'(r));
      assign dst_hit[r]  = disp_valid && disp_d_use && (disp_d_tag == TAG_W'(r));
      assign s0_oh[r]    = disp_s0_tag == TAG_W'(r);
      assign s1_oh[r]    = disp_s1_tag == TAG_W'(r);
   end

   // Completion is seen before the dispatch lookup of the same cycle.
   assign rdy_eff = reg_rdy | cmpl_hit;

   assign s0_wait = disp_valid && disp_s0_use && !disp_s0_rdy &&
                    (|s0_oh) && !(|(s0_oh & rdy_eff));
   assign s1_wait = disp_valid && disp_s1_use && !disp_s1_rdy &&
                    (|s1_oh) && !(|(s1_oh & rdy_eff));

   for (genvar e = 0; e < NUM_SLOTS; e++) begin : g_idoh
      assign id_oh[e]     = disp_id == ID_W'(e);
      assign drop_mask[e] = clr_valid && (clr_id == ID_W'(e));
   end

   for (genvar r = 0; r < NUM_PREGS; r++) begin : g_add
      assign add_wait[r] = ((s0_wait && s0_oh[r]) || (s1_wait && s1_oh[r])) ?
                           id_oh : '0;
   end

   always_comb begin
      wake = '0;
      for (int r = 0; r < NUM_PREGS; r++)
         wake = wake | (cmpl_hit[r] ? waiters[r] : '0);
   end

   assign disp_cls = ws_classify(disp_kind);

   ws_regfile #(
      .NUM_PREGS (NUM_PREGS),
      .NUM_SLOTS (NUM_SLOTS)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmpl_hit  (cmpl_hit),
      .dst_hit   (dst_hit),
      .dst_id    (disp_id),
      .add_wait  (add_wait),
      .drop_mask (drop_mask),
      .reg_rdy   (reg_rdy),
      .waiters   (waiters),
      .prod_vld  (prod_vld),
      .prod_id   (prod_id)
   );

   for (genvar e = 0; e < NUM_SLOTS; e++) begin : g_slot
      logic    busy;
      ws_cls_e cls_o;

      ws_slot #(
         .TAG_W (TAG_W)
      ) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .alloc      (disp_valid && id_oh[e]),
         .alloc_wait ({s1_wait, s0_wait}),
         .alloc_tag0 (disp_s0_tag),
         .alloc_tag1 (disp_s1_tag),
         .alloc_cls  (disp_cls),
         .wake       (wake[e]),
         .wake_tag   (cmpl_tag),
         .kill       (drop_mask[e]),
         .busy       (busy),
         .fire_q     (ready_vec[e]),
         .cls_q      (cls_o)
      );

      assign ready_cls[e*CLS_W +: CLS_W] = cls_o;
   end

endmodule

// File: rtl/ws_checker.sv
module ws_checker #(
   parameter int NUM_PREGS = 16,
   parameter int NUM_SLOTS = 8,
   parameter int TAG_W     = 5,
   localparam int ID_W     = $clog2(NUM_SLOTS),
   localparam int IDX_W    = $clog2(NUM_PREGS)
) (
   input logic                                clk,
   input logic                                rst_n,
   input logic                                disp_valid,
   input logic [ID_W-1:0]                     disp_id,
   input logic                                disp_d_use,
   input logic [TAG_W-1:0]                    disp_d_tag,
   input logic                                cmpl_valid,
   input logic [TAG_W-1:0]                    cmpl_tag,
   input logic                                clr_valid,
   input logic [ID_W-1:0]                     clr_id,
   input logic [NUM_SLOTS-1:0]                ready_vec,
   input logic [NUM_PREGS-1:0]                reg_rdy,
   input logic [NUM_PREGS-1:0][NUM_SLOTS-1:0] waiters,
   input logic [NUM_PREGS-1:0]                prod_vld,
   input logic [NUM_PREGS-1:0][ID_W-1:0]      prod_id
);
   localparam logic [TAG_W:0] NP_T = (TAG_W+1)'(NUM_PREGS);

   logic d_in, c_in;
   logic [IDX_W-1:0] d_idx, c_idx, d_idx_q, c_idx_q;
   logic [ID_W-1:0]  id_q, clr_q;
   logic             clr_col_any;

   assign d_in  = disp_valid && disp_d_use && ({1'b0, disp_d_tag} < NP_T);
   assign c_in  = cmpl_valid && ({1'b0, cmpl_tag} < NP_T);
   assign d_idx = disp_d_tag[IDX_W-1:0];
   assign c_idx = cmpl_tag[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_idx_q <= '0;
         c_idx_q <= '0;
         id_q    <= '0;
         clr_q   <= '0;
      end else begin
         d_idx_q <= d_idx;
         c_idx_q <= c_idx;
         id_q    <= disp_id;
         clr_q   <= clr_id;
      end
   end

   always_comb begin
      clr_col_any = 1'b0;
      for (int r = 0; r < NUM_PREGS; r++)
         clr_col_any = clr_col_any | waiters[r][clr_q];
   end

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ready_vec == '0 && reg_rdy == '0));

   assert_dst_no_waiters_R2: assert property (@(posedge clk) disable iff (!rst_n)
      d_in |-> (waiters[d_idx] == '0));

   assert_dst_claims_R2: assert property (@(posedge clk) disable iff (!rst_n)
      d_in |=> (!reg_rdy[d_idx_q] && prod_vld[d_idx_q] && prod_id[d_idx_q] == id_q));

   assert_cmpl_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (c_in && !(d_in && d_idx == c_idx)) |=>
      (reg_rdy[c_idx_q] && !prod_vld[c_idx_q]));

   assert_cmpl_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
      c_in |=> (waiters[c_idx_q] == '0));

   assert_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_valid && !(disp_valid && disp_id == clr_id)) |=>
      (!ready_vec[clr_q] && !clr_col_any));

   assert_pulse_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_vec != '0) |-> $past(disp_valid || cmpl_valid));

endmodule

bind wakeup_scoreboard ws_checker #(
   .NUM_PREGS (NUM_PREGS),
   .NUM_SLOTS (NUM_SLOTS),
   .TAG_W     (TAG_W)
) u_ws_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .disp_valid (disp_valid),
   .disp_id    (disp_id),
   .disp_d_use (disp_d_use),
   .disp_d_tag (disp_d_tag),
   .cmpl_valid (cmpl_valid),
   .cmpl_tag   (cmpl_tag),
   .clr_valid  (clr_valid),
   .clr_id     (clr_id),
   .ready_vec  (ready_vec),
   .reg_rdy    (reg_rdy),
   .waiters    (waiters),
   .prod_vld   (prod_vld),
   .prod_id    (prod_id)
);

// File: tb/wakeup_scoreboard_tb.sv
module wakeup_scoreboard_tb;
   localparam int NP = 16;
   localparam int NE = 8;
   localparam int TW = 5;
   localparam int IW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic disp_valid = 0, disp_s0_use = 0, disp_s0_rdy = 0;
   logic disp_s1_use = 0, disp_s1_rdy = 0, disp_d_use = 0;
   logic [IW-1:0] disp_id = '0, clr_id = '0;
   logic [3:0]    disp_kind = '0;
   logic [TW-1:0] disp_s0_tag = '0, disp_s1_tag = '0, disp_d_tag = '0, cmpl_tag = '0;
   logic cmpl_valid = 0, clr_valid = 0;
   logic [NE-1:0]   ready_vec;
   logic [3*NE-1:0] ready_cls;

   int n_chk = 0;
   int n_bad = 0;

   bit m_rdy [NP];
   bit m_busy [NE];
   bit m_w0 [NE];
   bit m_w1 [NE];
   int m_t0 [NE];
   int m_t1 [NE];
   int m_cls [NE];
   logic [NE-1:0] exp_vec;
   int exp_cls [NE];

   always #4 clk = ~clk;

   wakeup_scoreboard #(.NUM_PREGS(NP), .NUM_SLOTS(NE), .TAG_W(TW)) u_dut (
      .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_id(disp_id),
      .disp_kind(disp_kind), .disp_s0_use(disp_s0_use), .disp_s0_tag(disp_s0_tag),
      .disp_s0_rdy(disp_s0_rdy), .disp_s1_use(disp_s1_use), .disp_s1_tag(disp_s1_tag),
      .disp_s1_rdy(disp_s1_rdy), .disp_d_use(disp_d_use), .disp_d_tag(disp_d_tag),
      .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag), .clr_valid(clr_valid),
      .clr_id(clr_id), .ready_vec(ready_vec), .ready_cls(ready_cls));

   function automatic int classify(logic [3:0] k);
      if (k[3]) return 4;
      if (k[2]) return 3;
      if (k[1]) return 2;
      if (k[0]) return 1;
      return 0;
   endfunction

   function automatic int waiters_on(int r);
      int n = 0;
      for (int e = 0; e < NE; e++)
         if (m_busy[e] && ((m_w0[e] && m_t0[e] == r) || (m_w1[e] && m_t1[e] == r)))
            n++;
      return n;
   endfunction

   task automatic check(bit ok, string req, string what, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic idle();
      disp_valid = 0; disp_s0_use = 0; disp_s0_rdy = 0; disp_s1_use = 0;
      disp_s1_rdy = 0; disp_d_use = 0; disp_kind = '0; cmpl_valid = 0; clr_valid = 0;
   endtask

   // Expected behaviour from the requirements: completion, then clear, then dispatch.
   task automatic model_step();
      int ct;
      bit w0, w1;
      exp_vec = '0;
      ct = int'(cmpl_tag);
      if (cmpl_valid && ct < NP) begin
         for (int e = 0; e < NE; e++) begin
            if (m_busy[e] && !(clr_valid && int'(clr_id) == e)) begin
               if (m_w0[e] && m_t0[e] == ct) m_w0[e] = 0;
               if (m_w1[e] && m_t1[e] == ct) m_w1[e] = 0;
               if (!m_w0[e] && !m_w1[e]) begin
                  exp_vec[e] = 1'b1;
                  exp_cls[e] = m_cls[e];
                  m_busy[e] = 0;
               end
            end
         end
         m_rdy[ct] = 1;
      end
      if (clr_valid) begin
         m_busy[clr_id] = 0; m_w0[clr_id] = 0; m_w1[clr_id] = 0;
      end
      if (disp_valid) begin
         w0 = disp_s0_use && !disp_s0_rdy && int'(disp_s0_tag) < NP && !m_rdy[disp_s0_tag];
         w1 = disp_s1_use && !disp_s1_rdy && int'(disp_s1_tag) < NP && !m_rdy[disp_s1_tag];
         m_cls[disp_id] = classify(disp_kind);
         if (!w0 && !w1) begin
            exp_vec[disp_id] = 1'b1;
            exp_cls[disp_id] = m_cls[disp_id];
         end else begin
            m_busy[disp_id] = 1; m_w0[disp_id] = w0; m_w1[disp_id] = w1;
            m_t0[disp_id] = int'(disp_s0_tag); m_t1[disp_id] = int'(disp_s1_tag);
         end
         if (disp_d_use && int'(disp_d_tag) < NP) m_rdy[disp_d_tag] = 0;
      end
   endtask

   task automatic tick(string req);
      model_step();
      @(negedge clk);
      check(ready_vec === exp_vec, req, "ready_vec", int'(ready_vec), int'(exp_vec));
      for (int e = 0; e < NE; e++)
         if (exp_vec[e])
            check(int'(ready_cls[e*3 +: 3]) == exp_cls[e], "R8", "class code",
                  int'(ready_cls[e*3 +: 3]), exp_cls[e]);
      idle();
   endtask

   task automatic disp(int id, int kind, bit u0, int t0, bit r0, bit u1, int t1, bit r1,
                       bit du, int dt);
      disp_valid = 1; disp_id = IW'(id); disp_kind = 4'(kind);
      disp_s0_use = u0; disp_s0_tag = TW'(t0); disp_s0_rdy = r0;
      disp_s1_use = u1; disp_s1_tag = TW'(t1); disp_s1_rdy = r1;
      disp_d_use = du; disp_d_tag = TW'(dt);
   endtask

   task automatic cmpl(int t);
      cmpl_valid = 1; cmpl_tag = TW'(t);
   endtask

   task automatic clr(int id);
      clr_valid = 1; clr_id = IW'(id);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      for (int r = 0; r < NP; r++) m_rdy[r] = 0;
      for (int e = 0; e < NE; e++) begin
         m_busy[e] = 0; m_w0[e] = 0; m_w1[e] = 0; m_cls[e] = 0; exp_cls[e] = 0;
      end
      repeat (3) @(negedge clk);
      check(ready_vec == '0, "R1", "ready_vec in reset", int'(ready_vec), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(ready_vec == '0, "R1", "ready_vec after reset", int'(ready_vec), 0);

      disp(0, 0, 1, 3, 0, 0, 0, 0, 0, 0);   tick("R1 waits on cleared bit");
      cmpl(3);                              tick("R5 wake");
      tick("R11 pulse lasts one cycle");
      disp(1, 15, 1, 5, 1, 0, 0, 0, 0, 0);  tick("R3 flagged source");
      disp(2, 6, 1, 3, 0, 0, 0, 0, 0, 0);   tick("R4 scoreboard recheck");
      disp(3, 2, 0, 0, 0, 0, 0, 0, 1, 3);   tick("R2 producer dispatch");
      disp(4, 0, 1, 3, 0, 0, 0, 0, 0, 0);   tick("R2 consumer waits");
      cmpl(3);                              tick("R5 wake after R2");
      disp(5, 0, 1, 7, 0, 1, 8, 0, 0, 0);   tick("R6 two waits");
      cmpl(7);                              tick("R6 half resolved");
      cmpl(8);                              tick("R6 both resolved");
      disp(6, 0, 1, 9, 0, 1, 9, 0, 0, 0);   tick("R6 same register twice");
      cmpl(9);                              tick("R6 one completion frees both");
      disp(0, 0, 1, 17, 0, 0, 0, 0, 0, 0);  tick("R7 source out of range");
      disp(1, 0, 0, 0, 0, 0, 0, 0, 1, 19);  tick("R7 destination out of range");
      disp(2, 0, 1, 3, 0, 0, 0, 0, 0, 0);   tick("R7 aliased register untouched");
      disp(3, 0, 1, 10, 0, 0, 0, 0, 0, 0);  tick("R7 probe waits");
      cmpl(26);                             tick("R7 completion out of range");
      cmpl(10);                             tick("R5 probe freed");
      disp(4, 0, 1, 11, 0, 0, 0, 0, 0, 0); cmpl(11); tick("R9 same-cycle completion");
      disp(5, 0, 1, 12, 0, 0, 0, 0, 0, 0);  tick("R10 setup");
      clr(5);                               tick("R10 clear");
      cmpl(12);                             tick("R10 no pulse after clear");
      disp(6, 0, 1, 13, 0, 0, 0, 0, 0, 0);  tick("R10 setup");
      clr(6); cmpl(13);                     tick("R10 clear with completion");
      disp(0, 1, 0, 0, 0, 0, 0, 0, 0, 0);   tick("R8 fp");
      disp(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);   tick("R8 misc");
      disp(2, 3, 0, 0, 0, 0, 0, 0, 0, 0);   tick("R8 int over fp");
      disp(3, 5, 0, 0, 0, 0, 0, 0, 0, 0);   tick("R8 mem over fp");
      disp(4, 8, 0, 0, 0, 0, 0, 0, 0, 0);   tick("R8 ctl");

      for (int i = 0; i < 4000; i++) begin
         int e, d, t0, t1, c;
         e = int'($urandom_range(NE-1, 0));
         if (!m_busy[e] && $urandom_range(3, 0) != 0) begin
            t0 = int'($urandom_range(19, 0));
            t1 = int'($urandom_range(19, 0));
            d  = int'($urandom_range(19, 0));
            disp(e, int'($urandom_range(15, 0)), 1'($urandom), t0, ($urandom_range(3, 0) == 0),
                 1'($urandom), t1, ($urandom_range(3, 0) == 0), 1'($urandom), d);
            if (d == t0 || d == t1 || (d < NP && waiters_on(d) != 0)) disp_d_use = 0;
         end
         if ($urandom_range(1, 0) == 1) cmpl(int'($urandom_range(19, 0)));
         if ($urandom_range(7, 0) == 0) begin
            c = int'($urandom_range(NE-1, 0));
            if (m_busy[c] && !(disp_valid && int'(disp_id) == c)) clr(c);
         end
         tick("R5 R6 R11 random");
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule